// File: doc/BRIEF.md
# Pre/Post-Trigger Acquisition Sequencer

This block runs one sample-capture run at a time and tells an external sample buffer when to store a scan. A start trigger opens the run. The start trigger is edge-detected, and its active edge is selectable. The block has two modes:

- **Post-trigger mode:** the block stores a programmed number of scans after the start trigger and then stops.
- **Pre-trigger mode:** the block writes every sample tick into the buffer, with no limit, while it waits for a second trigger. When the second trigger arrives, the block stores the programmed number of further scans and then stops.

Each accepted trigger is echoed as a one-cycle pulse on a matching output. Both echo outputs stay low until software enables them. A restart command aborts a run at any point. The sample buffer, bus transfers and converter timing all live outside this block.

Top module: `acq_seq`

## Requirements
- R1: After reset `busy`, `done`, `buf_we`, `start_echo` and `post_echo` are 0 and `scan_cnt` is 0.
- R2: With `cfg_start_fall`=0 a 0→1 change of `start_trig` begins a run; with `cfg_start_fall`=1 only a 1→0 change does, and the opposite edge leaves `busy` at 0.
- R3: In post-trigger mode (`cfg_pre_mode`=0) exactly `cfg_post_cnt` ticks of `smp_tick` after the start produce `buf_we`, and `scan_cnt` ends equal to `cfg_post_cnt`.
- R4: In pre-trigger mode (`cfg_pre_mode`=1) every `smp_tick` after the start produces `buf_we` until the second trigger; `scan_cnt` stays 0 during this phase.
- R5: In pre-trigger mode a 0→1 change of `post_trig` starts the post phase, in which `cfg_post_cnt` further scans are stored before the run stops.
- R6: `post_trig` edges are ignored while idle, and they are also ignored after the first accepted one until the run ends; a repeat edge does not reload the count.
- R7: `done` is high for exactly the cycle in which the last post-trigger scan is written, and `busy` is 0 on the next cycle.
- R8: With `cfg_post_cnt`=0 the qualifying trigger raises `done` in the same cycle, no scan is written after it, and `scan_cnt` reads 0.
- R9: `start_echo` and `post_echo` each pulse for one cycle, the cycle after the start or second trigger is accepted. Both are held at 0 while `cfg_echo_en`=0.
- R10: `restart` returns the block to idle on the next cycle. In its own cycle it suppresses `buf_we` and `done`, even on the final tick of a run.
- R11: While idle, `smp_tick` never produces `buf_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_tick | input | 1 | One-cycle sample-clock tick |
| start_trig | input | 1 | Start trigger line (synchronous) |
| post_trig | input | 1 | Second trigger line, rising edge active |
| restart | input | 1 | Abort the run and return to idle |
| cfg_pre_mode | input | 1 | 0 = post-trigger mode, 1 = pre-trigger mode |
| cfg_start_fall | input | 1 | 0 = rising start edge, 1 = falling start edge |
| cfg_post_cnt | input | CNT_W | Number of scans stored after the trigger |
| cfg_echo_en | input | 1 | Enables both echo outputs |
| buf_we | output | 1 | Sample buffer write enable |
| scan_cnt | output | CNT_W | Post-trigger scans stored in this run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse on the final scan write |
| start_echo | output | 1 | Pulse echoing the accepted start trigger |
| post_echo | output | 1 | Pulse echoing the accepted second trigger |

## Verification
Two functions can fall in the same cycle: the final post-trigger tick, which should raise `done` and `buf_we`, and a `restart` command. The bench raises both in one cycle and requires that neither `buf_we` nor `done` appears, and that `busy` is low on the next cycle. A second collision is a repeat second trigger that lands while post-phase ticks are running. It is judged by checking that `done` still arrives on the originally programmed tick.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2
  } acq_state_t;
endpackage

// File: rtl/acq_edge_det.sv
module acq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic sel_fall,
  output logic edge_hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_in;
  end

  assign edge_hit = sel_fall ? (prev_q & ~sig_in) : (sig_in & ~prev_q);
endmodule

// File: rtl/acq_scan_ctr.sv
module acq_scan_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] load_val,
  output logic             last,
  output logic [CNT_W-1:0] scan_cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q, rem_d, cnt_q, cnt_d;
  logic             cen;

  assign cen = load | step;

  always_comb begin
    rem_d = rem_q;
    cnt_d = cnt_q;
    if (load) begin
      rem_d = load_val;
      cnt_d = '0;
    end else if (step) begin
      rem_d = rem_q - ONE;
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      cnt_q <= '0;
    end else if (cen) begin
      rem_q <= rem_d;
      cnt_q <= cnt_d;
    end
  end

  assign last     = (rem_q == ONE);
  assign scan_cnt = cnt_q;
endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
  import acq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_hit,
  input  logic post_hit,
  input  logic tick,
  input  logic restart,
  input  logic mode_pre,
  input  logic cnt_zero,
  input  logic last,
  output logic active,
  output logic load,
  output logic step,
  output logic wr_en,
  output logic fin,
  output logic start_acc,
  output logic post_acc
);
  acq_state_t state_q, state_d;

  always_comb begin
    state_d   = state_q;
    step      = 1'b0;
    wr_en     = 1'b0;
    fin       = 1'b0;
    start_acc = 1'b0;
    post_acc  = 1'b0;
    if (restart) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_hit) begin
            start_acc = 1'b1;
            if (mode_pre)      state_d = ST_PRE;
            else if (cnt_zero) fin     = 1'b1;
            else               state_d = ST_POST;
          end
        end
        ST_PRE: begin
          wr_en = tick;
          if (post_hit) begin
            post_acc = 1'b1;
            if (cnt_zero) begin
              fin     = 1'b1;
              state_d = ST_IDLE;
            end else begin
              state_d = ST_POST;
            end
          end
        end
        ST_POST: begin
          wr_en = tick;
          step  = tick;
          if (tick && last) begin
            fin     = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign load   = start_acc | post_acc;
  assign active = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/acq_seq.sv
module acq_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_tick,
  input  logic             start_trig,
  input  logic             post_trig,
  input  logic             restart,
  input  logic             cfg_pre_mode,
  input  logic             cfg_start_fall,
  input  logic [CNT_W-1:0] cfg_post_cnt,
  input  logic             cfg_echo_en,
  output logic             buf_we,
  output logic [CNT_W-1:0] scan_cnt,
  output logic             busy,
  output logic             done,
  output logic             start_echo,
  output logic             post_echo
);
  logic start_hit, post_hit, last, load, step, start_acc, post_acc;
  logic start_ech_q, post_ech_q;

  acq_edge_det u_start_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(start_trig),
    .sel_fall(cfg_start_fall), .edge_hit(start_hit)
  );

  acq_edge_det u_post_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(post_trig),
    .sel_fall(1'b0), .edge_hit(post_hit)
  );

  acq_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_hit(start_hit), .post_hit(post_hit),
    .tick(smp_tick), .restart(restart), .mode_pre(cfg_pre_mode),
    .cnt_zero(cfg_post_cnt == '0), .last(last), .active(busy),
    .load(load), .step(step), .wr_en(buf_we), .fin(done),
    .start_acc(start_acc), .post_acc(post_acc)
  );

  acq_scan_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .load_val(cfg_post_cnt), .last(last), .scan_cnt(scan_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_ech_q <= 1'b0;
      post_ech_q  <= 1'b0;
    end else begin
      start_ech_q <= start_acc;
      post_ech_q  <= post_acc;
    end
  end

  assign start_echo = start_ech_q & cfg_echo_en;
  assign post_echo  = post_ech_q & cfg_echo_en;
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_tick,
  input logic             restart,
  input logic             cfg_echo_en,
  input logic             buf_we,
  input logic [CNT_W-1:0] scan_cnt,
  input logic             busy,
  input logic             done,
  input logic             start_echo,
  input logic             post_echo
);
  AST_NO_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !buf_we);  // R11
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);  // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7
  AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !busy);  // R10
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !buf_we && !done);  // R10
  AST_ECHO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_echo_en |-> !start_echo && !post_echo);  // R9
  AST_START_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && cfg_echo_en) |-> start_echo);  // R9
  AST_WE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> smp_tick);  // R3
endmodule

bind acq_seq acq_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .restart(restart),
  .cfg_echo_en(cfg_echo_en), .buf_we(buf_we), .scan_cnt(scan_cnt),
  .busy(busy), .done(done), .start_echo(start_echo), .post_echo(post_echo)
);

// File: tb/acq_seq_tb.sv
module acq_seq_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic smp_tick, start_trig, post_trig, restart;
  logic cfg_pre_mode, cfg_start_fall, cfg_echo_en;
  logic [CNT_W-1:0] cfg_post_cnt;
  logic buf_we, busy, done, start_echo, post_echo;
  logic [CNT_W-1:0] scan_cnt;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  acq_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .start_trig(start_trig),
    .post_trig(post_trig), .restart(restart), .cfg_pre_mode(cfg_pre_mode),
    .cfg_start_fall(cfg_start_fall), .cfg_post_cnt(cfg_post_cnt),
    .cfg_echo_en(cfg_echo_en), .buf_we(buf_we), .scan_cnt(scan_cnt),
    .busy(busy), .done(done), .start_echo(start_echo), .post_echo(post_echo)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // set inputs after a falling edge, settle, then look
  task automatic cyc(input logic st, input logic pt, input logic tk, input logic rs);
    @(negedge clk);
    start_trig = st; post_trig = pt; smp_tick = tk; restart = rs;
    #1;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 buf_we", buf_we, 0);
    chk("R1 scan_cnt", scan_cnt, 0);
    chk("R1 echoes", {start_echo, post_echo}, 0);
  endtask

  task automatic t_idle_ignore;
    cfg_pre_mode = 1'b1; cfg_post_cnt = 16'd2;
    cyc(0, 1, 1, 0);
    chk("R11 idle tick no write", buf_we, 0);
    cyc(0, 0, 1, 0);
    chk("R6 post edge in idle ignored", busy, 0);
    chk("R11 idle tick no write 2", buf_we, 0);
    cyc(0, 0, 0, 0);
  endtask

  task automatic t_post_run;
    cfg_pre_mode = 1'b0; cfg_post_cnt = 16'd3; cfg_start_fall = 1'b0;
    cyc(1, 0, 0, 0);
    chk("R2 rising start not busy yet", busy, 0);
    cyc(0, 0, 1, 0);
    chk("R2 busy after rising start", busy, 1);
    chk("R9 start_echo pulse", start_echo, 1);
    chk("R3 write 1", buf_we, 1);
    chk("R7 no done at 1", done, 0);
    cyc(0, 0, 0, 0);
    chk("R9 start_echo single", start_echo, 0);
    chk("R3 no write w/o tick", buf_we, 0);
    cyc(0, 0, 1, 0);
    chk("R3 write 2", buf_we, 1);
    chk("R7 no done at 2", done, 0);
    cyc(0, 0, 1, 0);
    chk("R3 write 3", buf_we, 1);
    chk("R7 done on last", done, 1);
    cyc(0, 0, 1, 0);
    chk("R7 idle after done", busy, 0);
    chk("R3 no write after run", buf_we, 0);
    chk("R3 scan_cnt final", scan_cnt, 3);
    chk("R7 done single", done, 0);
    cyc(0, 0, 0, 0);
  endtask

  task automatic t_fall;
    cfg_pre_mode = 1'b0; cfg_post_cnt = 16'd1; cfg_start_fall = 1'b1;
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    chk("R2 rising ignored in fall mode", busy, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R2 falling start accepted", busy, 1);
    chk("R7 done N=1", done, 1);
    cyc(0, 0, 0, 0);
    chk("R2 run ended", busy, 0);
    cfg_start_fall = 1'b0;
    cyc(0, 0, 0, 0);
  endtask

  task automatic t_pre_run;
    cfg_pre_mode = 1'b1; cfg_post_cnt = 16'd2;
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 1, 0);
      chk("R4 pre write", buf_we, 1);
      chk("R4 pre busy", busy, 1);
      chk("R4 pre scan_cnt", scan_cnt, 0);
    end
    cyc(0, 1, 0, 0);
    chk("R5 no done at second trigger", done, 0);
    cyc(0, 0, 1, 0);
    chk("R9 post_echo pulse", post_echo, 1);
    chk("R5 post write 1", buf_we, 1);
    chk("R5 no done yet", done, 0);
    cyc(0, 1, 0, 0);
    chk("R9 post_echo single", post_echo, 0);
    cyc(0, 0, 1, 0);
    chk("R6 repeat edge ignored, post write 2", buf_we, 1);
    chk("R6 done on original count", done, 1);
    chk("R9 no echo for repeat", post_echo, 0);
    cyc(0, 0, 0, 0);
    chk("R5 stopped", busy, 0);
    chk("R5 scan_cnt", scan_cnt, 2);
  endtask

  task automatic t_zero;
    cfg_pre_mode = 1'b0; cfg_post_cnt = 16'd0;
    cyc(1, 0, 1, 0);
    chk("R8 done on trigger", done, 1);
    chk("R8 no write", buf_we, 0);
    cyc(0, 0, 1, 0);
    chk("R8 not busy", busy, 0);
    chk("R8 no later write", buf_we, 0);
    chk("R8 scan_cnt zero", scan_cnt, 0);
  endtask

  task automatic t_restart;
    cfg_pre_mode = 1'b0; cfg_post_cnt = 16'd2;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R10 setup write", buf_we, 1);
    cyc(0, 0, 1, 1);
    chk("R10 restart blocks write", buf_we, 0);
    chk("R10 restart blocks done", done, 0);
    cyc(0, 0, 1, 0);
    chk("R10 idle after restart", busy, 0);
    chk("R10 no write after restart", buf_we, 0);
  endtask

  task automatic t_echo_off;
    cfg_echo_en = 1'b0; cfg_pre_mode = 1'b0; cfg_post_cnt = 16'd1;
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R9 start_echo gated", start_echo, 0);
    chk("R9 run still busy", busy, 1);
    cyc(0, 0, 0, 0);
    cfg_echo_en = 1'b1;
  endtask

  initial begin
    #800000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    rst_n = 1'b0;
    smp_tick = 0; start_trig = 0; post_trig = 0; restart = 0;
    cfg_pre_mode = 0; cfg_start_fall = 0; cfg_echo_en = 1; cfg_post_cnt = '0;
    #10;
    @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_idle_ignore();
    t_post_run();
    t_fall();
    t_pre_run();
    t_zero();
    t_restart();
    t_echo_off();
    report();
  end
endmodule